// File: doc/BRIEF.md
# Lockable System Status Register Bank

This block is a small bank of board-level status and control words sitting on a plain 32-bit register bus. The bus has a word address, a write enable, a read enable, write data and read data. Software reads a fixed identity word and drives a set of LEDs. It keeps two scratch configuration words and two flag words. One flag word is volatile. The other keeps its contents across an ordinary reset and is cleared only by power-on reset. Each flag word has one address that sets bits and another that clears them, so software never needs a read-modify-write sequence.

A reset-control word lets software request a system reset. Writes to it are accepted only while a 16-bit guard register holds the unlock code 0xA05F. Any other value written to the guard register is stored with bit 15 forced low, so the guard can only read back as unlocked after the exact code has been written. The bank also shows two media pins (card present, write protect) and a free-running tick counter. Known but unimplemented offsets read as zero. Unknown offsets read as zero and also raise a one-cycle bad-access flag.

Top module: `sysRegBank`

## Requirements
- R1: While `rstN` or `porN` is low, and after either is released, LED (0x08), guard (0x20), both config words (0x28, 0x2C), flags (0x30) and reset level (0x40) read 0. Offset 0x00 reads the fixed identity word, with the board code in bits [27:16] (default 0x11780400). Offset 0x44 always reads 1.
- R2: Reads are registered. `busRdata` takes the addressed value at the clock edge that samples `busRe` high, and holds that value while `busRe` is low. A write and a read in the same cycle return the value from before the write.
- R3: A write to 0x20 with data exactly 0x0000A05F stores 0xA05F. Any other write stores data[14:0] with bit 15 clear. Reading 0x20 returns the stored 16 bits, zero-extended.
- R4: A write to 0x30 ORs the data into the volatile flag word. A write to 0x34 clears each flag bit that is 1 in the data. The word is read back at 0x30.
- R5: Offsets 0x38 (set, read) and 0x3C (clear) act the same way on the non-volatile flag word. This word keeps its value through `rstN` and is cleared only by `porN`.
- R6: A write to 0x40 is ignored unless the guard register holds 0xA05F. An accepted value is stored and read back at 0x40.
- R7: `resetReq` is high for exactly the one cycle after an accepted write to 0x40 whose data has bit `RST_BIT` set (default 8). It stays low for a rejected write, and for an accepted write with that bit clear.
- R8: Offset 0x08 is a read/write LED word that drives the `leds` output. Offsets 0x28 and 0x2C are read/write config words.
- R9: Offset 0x48 shows `cardDetect` at bit 0 and `writeProt` at bit `WP_BIT` (1 or 2, default 2). All other bits read 0.
- R10: Offset 0x5C returns a counter that advances by one on every clock with `tickEn` high. It is zero after reset.
- R11: Reserved offsets (0x04, 0x0C-0x1C, 0x24, 0x34, 0x3C, 0x4C-0x58, 0x60-0x74, 0x80-0x9C, 0xC0-0xD0) read 0 with `badAccess` low. Every other offset, including non-word-aligned ones, reads 0 and raises `badAccess` for the one cycle in which the read data appears.
- R12: Writes to read-only, reserved or undefined offsets (for example 0x00, 0x44, 0x78) change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous ordinary reset |
| porN | input | 1 | Active-low asynchronous power-on reset, also clears the non-volatile flags |
| tickEn | input | 1 | Advances the tick counter by one when high |
| busAddr | input | 8 | Byte address of the access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| badAccess | output | 1 | One-cycle flag for a read of an undefined offset |
| cardDetect | input | 1 | Card-present pin |
| writeProt | input | 1 | Write-protect pin |
| leds | output | 32 | LED word |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is an accepted reset-control write. It depends on earlier guard-register history, so the stimulus has to cover several cases in order. It first writes a near-miss guard value (bit 15 set, wrong code) and checks that the 0x40 write is refused with no pulse. It then writes the exact code and issues writes with and without the reset bit. The non-volatile word needs an ordinary reset applied between setting it and reading it back, followed later by a power-on reset. A behavioural reference model runs in step on every clock and covers all of these sequences.

// File: rtl/sysRegPkg.sv
package sysRegPkg;

  localparam logic [15:0] LOCK_MAGIC = 16'hA05F;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_LED    = 8'h08;
  localparam logic [7:0] OFF_LOCK   = 8'h20;
  localparam logic [7:0] OFF_CFGA   = 8'h28;
  localparam logic [7:0] OFF_CFGB   = 8'h2C;
  localparam logic [7:0] OFF_FSET   = 8'h30;
  localparam logic [7:0] OFF_FCLR   = 8'h34;
  localparam logic [7:0] OFF_NSET   = 8'h38;
  localparam logic [7:0] OFF_NCLR   = 8'h3C;
  localparam logic [7:0] OFF_RSTCTL = 8'h40;
  localparam logic [7:0] OFF_ONE    = 8'h44;
  localparam logic [7:0] OFF_MEDIA  = 8'h48;
  localparam logic [7:0] OFF_TICK   = 8'h5C;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ID, SEL_LED, SEL_LOCK, SEL_CFGA, SEL_CFGB,
    SEL_FLAGS, SEL_NV, SEL_RST, SEL_ONE, SEL_MEDIA, SEL_TICK
  } rdSel_e;

  typedef struct packed {
    logic   wrLed;
    logic   wrLock;
    logic   wrCfgA;
    logic   wrCfgB;
    logic   setFlags;
    logic   clrFlags;
    logic   setNv;
    logic   clrNv;
    logic   wrRstCtl;
    logic   rdEn;
    rdSel_e rdSel;
    logic   rdBad;
  } strobes_t;

endpackage

// File: rtl/sysRegCtrl.sv
module sysRegCtrl
  import sysRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstAllN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobes_t          st,
  output logic              badAccess
);

  logic [7:0] offs;
  logic       aligned;
  logic       reservedHit;
  rdSel_e     selComb;
  logic       knownHit;

  assign offs    = 8'(busAddr);
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    reservedHit = 1'b0;
    if (aligned) begin
      if (offs == 8'h04 || offs == 8'h24 || offs == OFF_FCLR || offs == OFF_NCLR)
        reservedHit = 1'b1;
      if (offs >= 8'h0C && offs <= 8'h1C) reservedHit = 1'b1;
      if (offs >= 8'h4C && offs <= 8'h58) reservedHit = 1'b1;
      if (offs >= 8'h60 && offs <= 8'h74) reservedHit = 1'b1;
      if (offs >= 8'h80 && offs <= 8'h9C) reservedHit = 1'b1;
      if (offs >= 8'hC0 && offs <= 8'hD0) reservedHit = 1'b1;
    end
  end

  always_comb begin
    selComb  = SEL_ZERO;
    knownHit = 1'b1;
    unique case (offs)
      OFF_ID:     selComb = SEL_ID;
      OFF_LED:    selComb = SEL_LED;
      OFF_LOCK:   selComb = SEL_LOCK;
      OFF_CFGA:   selComb = SEL_CFGA;
      OFF_CFGB:   selComb = SEL_CFGB;
      OFF_FSET:   selComb = SEL_FLAGS;
      OFF_NSET:   selComb = SEL_NV;
      OFF_RSTCTL: selComb = SEL_RST;
      OFF_ONE:    selComb = SEL_ONE;
      OFF_MEDIA:  selComb = SEL_MEDIA;
      OFF_TICK:   selComb = SEL_TICK;
      default:    knownHit = reservedHit;
    endcase
  end

  always_comb begin
    st          = '0;
    st.rdSel    = SEL_ZERO;
    st.rdEn     = busRe;
    if (busRe) begin
      st.rdSel = selComb;
      st.rdBad = !knownHit;
    end
    if (busWe) begin
      st.wrLed    = (offs == OFF_LED);
      st.wrLock   = (offs == OFF_LOCK);
      st.wrCfgA   = (offs == OFF_CFGA);
      st.wrCfgB   = (offs == OFF_CFGB);
      st.setFlags = (offs == OFF_FSET);
      st.clrFlags = (offs == OFF_FCLR);
      st.setNv    = (offs == OFF_NSET);
      st.clrNv    = (offs == OFF_NCLR);
      st.wrRstCtl = (offs == OFF_RSTCTL);
    end
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) badAccess <= 1'b0;
    else          badAccess <= st.rdBad;
  end

  // R11: the bad flag only follows a read strobe
  a_r11_bad_after_read: assert property (@(posedge clk) disable iff (!rstAllN)
    badAccess |-> $past(busRe));

  // R12: at most one write target per cycle
  a_r12_single_target: assert property (@(posedge clk) disable iff (!rstAllN)
    $onehot0({st.wrLed, st.wrLock, st.wrCfgA, st.wrCfgB, st.setFlags,
              st.clrFlags, st.setNv, st.clrNv, st.wrRstCtl}));

endmodule

// File: rtl/sysRegData.sv
module sysRegData
  import sysRegPkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          TICK_W     = 32,
  parameter logic [3:0]  ID_TOP     = 4'h1,
  parameter logic [11:0] BOARD_CODE = 12'h178,
  parameter logic [15:0] ID_LOW     = 16'h0400,
  parameter int          RST_BIT    = 8,
  parameter int          WP_BIT     = 2
) (
  input  logic              clk,
  input  logic              rstAllN,
  input  logic              porN,
  input  logic              tickEn,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cardDetect,
  input  logic              writeProt,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] leds,
  output logic              resetReq
);

  localparam int LOCK_W = 16;
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({ID_TOP, BOARD_CODE, ID_LOW});
  localparam logic [LOCK_W-1:0] LOCK_KEEP = {1'b0, {(LOCK_W-1){1'b1}}};

  logic [DATA_W-1:0] ledReg, cfgA, cfgB, flags, nvFlags, rstLevel;
  logic [LOCK_W-1:0] lockReg;
  logic [TICK_W-1:0] tickCnt;
  logic              unlocked;
  logic              acceptRst;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] mediaWord;

  assign unlocked  = (lockReg == LOCK_MAGIC);
  assign acceptRst = st.wrRstCtl && unlocked;
  assign leds      = ledReg;

  always_comb begin
    mediaWord         = '0;
    mediaWord[0]      = cardDetect;
    mediaWord[WP_BIT] = writeProt;
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) begin
      ledReg   <= '0;
      cfgA     <= '0;
      cfgB     <= '0;
      flags    <= '0;
      lockReg  <= '0;
      rstLevel <= '0;
      resetReq <= 1'b0;
    end else begin
      if (st.wrLed)    ledReg <= busWdata;
      if (st.wrCfgA)   cfgA   <= busWdata;
      if (st.wrCfgB)   cfgB   <= busWdata;
      if (st.setFlags) flags  <= flags | busWdata;
      if (st.clrFlags) flags  <= flags & ~busWdata;
      if (st.wrLock) begin
        if (busWdata == DATA_W'(LOCK_MAGIC)) lockReg <= LOCK_MAGIC;
        else                                 lockReg <= busWdata[LOCK_W-1:0] & LOCK_KEEP;
      end
      if (acceptRst) rstLevel <= busWdata;
      resetReq <= acceptRst && busWdata[RST_BIT];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      nvFlags <= '0;
    end else begin
      if (st.setNv) nvFlags <= nvFlags | busWdata;
      if (st.clrNv) nvFlags <= nvFlags & ~busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN)    tickCnt <= '0;
    else if (tickEn) tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    unique case (st.rdSel)
      SEL_ID:    rdMux = ID_WORD;
      SEL_LED:   rdMux = ledReg;
      SEL_LOCK:  rdMux = DATA_W'(lockReg);
      SEL_CFGA:  rdMux = cfgA;
      SEL_CFGB:  rdMux = cfgB;
      SEL_FLAGS: rdMux = flags;
      SEL_NV:    rdMux = nvFlags;
      SEL_RST:   rdMux = rstLevel;
      SEL_ONE:   rdMux = DATA_W'(1);
      SEL_MEDIA: rdMux = mediaWord;
      SEL_TICK:  rdMux = DATA_W'(tickCnt);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN)     busRdata <= '0;
    else if (st.rdEn) busRdata <= rdMux;
  end

  // R3: a non-magic guard write never leaves bit 15 set
  a_r3_guard_bit15: assert property (@(posedge clk) disable iff (!rstAllN)
    (st.wrLock && busWdata != DATA_W'(LOCK_MAGIC)) |=> !lockReg[LOCK_W-1]);

  // R4: after a set write every data bit reads as one
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rstAllN)
    st.setFlags |=> ((flags & $past(busWdata)) == $past(busWdata)));

  // R5: non-volatile word moves only on its own strobes
  a_r5_nv_quiet: assert property (@(posedge clk) disable iff (!porN)
    !(st.setNv || st.clrNv) |=> $stable(nvFlags));

  // R6: locked writes to reset control leave it unchanged
  a_r6_locked_ignored: assert property (@(posedge clk) disable iff (!rstAllN)
    (st.wrRstCtl && !unlocked) |=> $stable(rstLevel));

  // R7: the request only follows an accepted write with the reset bit
  a_r7_req_cause: assert property (@(posedge clk) disable iff (!rstAllN)
    $rose(resetReq) |-> $past(st.wrRstCtl && unlocked && busWdata[RST_BIT]));

endmodule

// File: rtl/sysRegBank.sv
module sysRegBank
  import sysRegPkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          TICK_W     = 32,
  parameter logic [11:0] BOARD_CODE = 12'h178,
  parameter int          RST_BIT    = 8,
  parameter int          WP_BIT     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              badAccess,
  input  logic              cardDetect,
  input  logic              writeProt,
  output logic [DATA_W-1:0] leds,
  output logic              resetReq
);

  logic     rstAllN;
  strobes_t st;

  assign rstAllN = rstN & porN;

  sysRegCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstAllN(rstAllN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .st(st), .badAccess(badAccess)
  );

  sysRegData #(
    .DATA_W(DATA_W), .TICK_W(TICK_W), .ID_TOP(4'h1), .BOARD_CODE(BOARD_CODE),
    .ID_LOW(16'h0400), .RST_BIT(RST_BIT), .WP_BIT(WP_BIT)
  ) uData (
    .clk(clk), .rstAllN(rstAllN), .porN(porN), .tickEn(tickEn), .st(st),
    .busWdata(busWdata), .cardDetect(cardDetect), .writeProt(writeProt),
    .busRdata(busRdata), .leds(leds), .resetReq(resetReq)
  );

endmodule

// File: tb/sysRegBank_test.sv
module sysRegBank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0, porN = 1'b0, tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, leds;
  logic        badAccess, resetReq;
  logic        cardDetect = 1'b0, writeProt = 1'b0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sysRegBank uut (
    .clk(clk), .rstN(rstN), .porN(porN), .tickEn(tickEn), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata),
    .badAccess(badAccess), .cardDetect(cardDetect), .writeProt(writeProt),
    .leds(leds), .resetReq(resetReq)
  );

  // behavioural reference model
  bit [31:0] mLed, mCfgA, mCfgB, mFlags, mNv, mRst, mTick, mRd;
  bit [15:0] mLock;
  bit        mBad, mReq;

  function automatic bit isReserved(bit [7:0] a);
    if (a[1:0] != 0) return 0;
    return a == 8'h04 || a == 8'h24 || a == 8'h34 || a == 8'h3C ||
           (a >= 8'h0C && a <= 8'h1C) || (a >= 8'h4C && a <= 8'h58) ||
           (a >= 8'h60 && a <= 8'h74) || (a >= 8'h80 && a <= 8'h9C) ||
           (a >= 8'hC0 && a <= 8'hD0);
  endfunction

  function automatic bit [32:0] modelRead(bit [7:0] a);
    case (a)
      8'h00: return {1'b0, 32'h11780400};
      8'h08: return {1'b0, mLed};
      8'h20: return {17'b0, mLock};
      8'h28: return {1'b0, mCfgA};
      8'h2C: return {1'b0, mCfgB};
      8'h30: return {1'b0, mFlags};
      8'h38: return {1'b0, mNv};
      8'h40: return {1'b0, mRst};
      8'h44: return 33'd1;
      8'h48: return {1'b0, 29'b0, writeProt, 1'b0, cardDetect};
      8'h5C: return {1'b0, mTick};
      default: return {!isReserved(a), 32'b0};
    endcase
  endfunction

  always @(posedge clk) begin
    bit [32:0] r;
    if (!porN) mNv = 0;
    if (!porN || !rstN) begin
      mLed = 0; mCfgA = 0; mCfgB = 0; mFlags = 0; mRst = 0; mTick = 0;
      mRd = 0; mLock = 0; mBad = 0; mReq = 0;
    end else begin
      mBad = 0;
      if (busRe) begin r = modelRead(busAddr); mRd = r[31:0]; mBad = r[32]; end
      mReq = busWe && busAddr == 8'h40 && mLock == 16'hA05F && busWdata[8];
      if (busWe) case (busAddr)
        8'h08: mLed = busWdata;
        8'h20: mLock = (busWdata == 32'hA05F) ? 16'hA05F : {1'b0, busWdata[14:0]};
        8'h28: mCfgA = busWdata;
        8'h2C: mCfgB = busWdata;
        8'h30: mFlags |= busWdata;
        8'h34: mFlags &= ~busWdata;
        8'h38: mNv |= busWdata;
        8'h3C: mNv &= ~busWdata;
        8'h40: if (mLock == 16'hA05F) mRst = busWdata;
        default: ;
      endcase
      if (tickEn) mTick++;
    end
  end

  task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 timing, all outputs)
  always @(posedge clk) begin
    #1;
    if (rstN && porN) begin
      check("R2 model rdata", busRdata, mRd);
      check("R11 model badAccess", {31'b0, badAccess}, {31'b0, mBad});
      check("R7 model resetReq", {31'b0, resetReq}, {31'b0, mReq});
      check("R8 model leds", leds, mLed);
    end
  end

  task automatic wr(bit [7:0] a, bit [31:0] d, bit expReq, string tag);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    check(tag, {31'b0, resetReq}, {31'b0, expReq});
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(bit [7:0] a, bit [31:0] exp, bit expBad, string tag);
    @(negedge clk); busRe = 1; busAddr = a;
    @(posedge clk); #1;
    check(tag, busRdata, exp);
    check(tag, {31'b0, badAccess}, {31'b0, expBad});
    @(negedge clk); busRe = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1; rstN = 1;
    // R1 reset state
    rd(8'h08, 0, 0, "R1 led");
    rd(8'h20, 0, 0, "R1 lock");
    rd(8'h30, 0, 0, "R1 flags");
    rd(8'h28, 0, 0, "R1 cfg");
    rd(8'h40, 0, 0, "R1 rstlevel");
    rd(8'h00, 32'h11780400, 0, "R1 id");
    rd(8'h44, 1, 0, "R1 one");
    // R8
    wr(8'h08, 32'h0000005A, 0, "R8 led wr");
    rd(8'h08, 32'h5A, 0, "R8 led rd");
    check("R8 leds port", leds, 32'h5A);
    wr(8'h2C, 32'hCAFE0001, 0, "R8 cfg wr");
    rd(8'h2C, 32'hCAFE0001, 0, "R8 cfg rd");
    // R3 and R6: near-miss guard value, reset write refused
    wr(8'h20, 32'h1234FFFF, 0, "R3 wr");
    rd(8'h20, 32'h7FFF, 0, "R3 masked");
    wr(8'h40, 32'h104, 0, "R6 locked no pulse");
    rd(8'h40, 0, 0, "R6 locked ignored");
    wr(8'h20, 32'hA05F, 0, "R3 magic wr");
    rd(8'h20, 32'hA05F, 0, "R3 magic");
    wr(8'h40, 32'h104, 1, "R7 pulse");
    @(posedge clk); #1; check("R7 pulse ends", {31'b0, resetReq}, 0);
    rd(8'h40, 32'h104, 0, "R6 accepted");
    wr(8'h40, 32'h004, 0, "R7 no bit");
    // R4
    wr(8'h30, 32'hF0, 0, "R4 set");
    wr(8'h30, 32'h0F, 0, "R4 set2");
    rd(8'h30, 32'hFF, 0, "R4 or");
    wr(8'h34, 32'h3C, 0, "R4 clr");
    rd(8'h30, 32'hC3, 0, "R4 andnot");
    // R5
    wr(8'h38, 32'hAA, 0, "R5 set");
    wr(8'h3C, 32'h02, 0, "R5 clr");
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    rd(8'h38, 32'hA8, 0, "R5 survives rstN");
    rd(8'h30, 0, 0, "R1 flags after rstN");
    @(negedge clk); porN = 0; @(negedge clk); porN = 1;
    rd(8'h38, 0, 0, "R5 por clears");
    // R9
    cardDetect = 1; writeProt = 1;
    rd(8'h48, 32'h5, 0, "R9 both");
    cardDetect = 0;
    rd(8'h48, 32'h4, 0, "R9 wp only");
    // R10
    @(negedge clk); tickEn = 1;
    repeat (10) @(negedge clk);
    tickEn = 0;
    rd(8'h5C, 32'd10, 0, "R10 tick");
    // R11
    rd(8'hA0, 0, 1, "R11 undefined");
    rd(8'h0C, 0, 0, "R11 reserved");
    rd(8'h09, 0, 1, "R11 unaligned");
    // R12
    wr(8'h00, 32'hFFFFFFFF, 0, "R12 id wr");
    rd(8'h00, 32'h11780400, 0, "R12 id kept");
    wr(8'h44, 32'h0, 0, "R12 one wr");
    rd(8'h44, 1, 0, "R12 one kept");
    wr(8'h78, 32'hFFFF, 0, "R12 undef wr");
    rd(8'h08, 0, 0, "R12 led kept");
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule